// File: doc/BRIEF.md
# Machine Trap Control Register Unit

This block keeps the four machine-level trap registers of a small processor core: a status word, the trap vector, the saved return address and the trap cause. When the pipeline reports that the current instruction has failed, either because it is an environment-call instruction or because an internal exception was raised, the unit redirects the program counter to the trap vector in the same cycle. At the next clock edge it captures the failing instruction's own address, with no adjustment, in the return-address register and records a cause number.

A trap-return request redirects the program counter to the saved return address. Software that wants to resume after an environment call adds 4 to that register itself. A single software access port reads and writes the registers by their 12-bit register numbers. An access returns the old contents in the same cycle and stores the new value at the clock edge, which is the swap behaviour a read-and-write instruction needs.

Top module: `trap_csr_unit`

## Requirements
- R1: After synchronous reset the status register reads 0x00001800 and the trap vector, return address and cause registers read 0.
- R2: The register numbers are status 0x300, trap vector 0x305, return address 0x341 and cause 0x342. A read of any other number returns 0, and a write to any other number changes no register.
- R3: `csr_rdata_o` always shows the current contents of the addressed register. A write with `csr_we_i` high stores `csr_wdata_i` at the clock edge, so the access cycle reads the old value and the following cycle reads the new value.
- R4: Bits 1:0 of the return-address register are stored as zero on every write, whether from the access port or from a trap.
- R5: A trap (`exc_valid_i` or `env_call_i` high) raises `redirect_o` in the same cycle with `redirect_pc_o` equal to the trap vector. At the next edge the return-address register takes `pc_i`, with no +4 adjustment.
- R6: An environment-call trap alone records cause 11. An exception records `exc_cause_i`. When both are raised together, the exception's cause is recorded.
- R7: A trap return (`trap_ret_i`) without a trap raises `redirect_o` with `redirect_pc_o` equal to the return-address register and changes no register. With no trap and no trap return, `redirect_o` is low.
- R8: When a trap and an access-port write happen in the same cycle, the trap's values win for the return-address and cause registers. A write to the status or trap-vector register in that cycle still takes effect, and the redirect uses the trap vector as it was before that write.
- R9: When a trap and a trap return happen in the same cycle, the trap wins: the target is the trap vector and the trap state is saved.
- R10: The status register is a plain 32-bit store: every bit written is read back unchanged, and traps and trap returns never modify it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_i | input | 32 | Address of the instruction in the trap stage |
| exc_valid_i | input | 1 | Internal exception raised by that instruction |
| exc_cause_i | input | 32 | Cause number of the internal exception |
| env_call_i | input | 1 | That instruction is an environment call |
| trap_ret_i | input | 1 | That instruction is a trap return |
| csr_we_i | input | 1 | Access-port write enable |
| csr_addr_i | input | 12 | Access-port register number |
| csr_wdata_i | input | 32 | Access-port write data |
| csr_rdata_o | output | 32 | Current contents of the addressed register |
| redirect_o | output | 1 | Program counter must be replaced this cycle |
| redirect_pc_o | output | 32 | Replacement program counter |

## Verification
The bench targets same-cycle collisions. A trap together with a write to the return-address or cause register catches a design that lets software overwrite the saved state. A trap together with a write to the trap vector catches a design that jumps to the newly written address. A trap together with a trap return catches a design that returns instead of trapping.

It also checks the saved address against the raw PC, which exposes a design that adds 4, and it writes unaligned values to the return address to expose missing masking. Writes to unmapped numbers must leave every register unchanged. A pseudo-random stream of mixed accesses and events is compared each cycle against a behavioural model, so that an inverted priority or a stale read path shows up as a mismatch.

// File: rtl/trap_csr_pkg.sv
package trap_csr_pkg;

    localparam int XLEN        = 32;
    localparam int CSR_AW      = 12;
    localparam int ALIGN_BITS  = 2;

    localparam logic [CSR_AW-1:0] NUM_STATUS   = 12'h300;
    localparam logic [CSR_AW-1:0] NUM_VECTOR   = 12'h305;
    localparam logic [CSR_AW-1:0] NUM_RET_ADDR = 12'h341;
    localparam logic [CSR_AW-1:0] NUM_CAUSE    = 12'h342;

    localparam logic [XLEN-1:0] STATUS_RESET = 32'h0000_1800;
    localparam logic [XLEN-1:0] CAUSE_ENV    = 32'd11;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_VECTOR,
        SEL_RET_ADDR,
        SEL_CAUSE
    } csr_sel_e;

    typedef struct packed {
        logic [XLEN-1:0] status;
        logic [XLEN-1:0] vector;
        logic [XLEN-1:0] ret_addr;
        logic [XLEN-1:0] cause;
    } csr_regs_t;

    typedef struct packed {
        logic            take;
        logic [XLEN-1:0] epc;
        logic [XLEN-1:0] cause;
    } trap_evt_t;

    function automatic csr_sel_e decode_num(input logic [CSR_AW-1:0] num);
        csr_sel_e s;
        case (num)
            NUM_STATUS:   s = SEL_STATUS;
            NUM_VECTOR:   s = SEL_VECTOR;
            NUM_RET_ADDR: s = SEL_RET_ADDR;
            NUM_CAUSE:    s = SEL_CAUSE;
            default:      s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic logic [XLEN-1:0] align_addr(input logic [XLEN-1:0] v);
        return {v[XLEN-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
    endfunction

endpackage

// File: rtl/trap_ctrl.sv
module trap_ctrl
    import trap_csr_pkg::*;
(
    input  logic [XLEN-1:0] pc_i,
    input  logic            exc_valid_i,
    input  logic [XLEN-1:0] exc_cause_i,
    input  logic            env_call_i,
    input  logic            trap_ret_i,
    input  csr_regs_t       regs_i,
    output trap_evt_t       evt_o,
    output logic            redirect_o,
    output logic [XLEN-1:0] redirect_pc_o
);

    always_comb begin
        evt_o.take  = exc_valid_i | env_call_i;
        evt_o.epc   = pc_i;
        evt_o.cause = exc_valid_i ? exc_cause_i : CAUSE_ENV;
    end

    always_comb begin
        redirect_o    = evt_o.take | trap_ret_i;
        redirect_pc_o = '0;
        if (evt_o.take) begin
            redirect_pc_o = regs_i.vector;
        end else if (trap_ret_i) begin
            redirect_pc_o = regs_i.ret_addr;
        end
    end

endmodule

// File: rtl/csr_file.sv
module csr_file
    import trap_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we_i,
    input  logic [CSR_AW-1:0] num_i,
    input  logic [XLEN-1:0]   wdata_i,
    input  trap_evt_t         evt_i,
    output logic [XLEN-1:0]   rdata_o,
    output csr_regs_t         regs_o
);

    csr_regs_t regs_q;
    csr_regs_t regs_d;
    csr_sel_e  sel;

    assign sel = decode_num(num_i);

    always_comb begin
        regs_d = regs_q;
        if (we_i) begin
            case (sel)
                SEL_STATUS:   regs_d.status   = wdata_i;
                SEL_VECTOR:   regs_d.vector   = wdata_i;
                SEL_RET_ADDR: regs_d.ret_addr = align_addr(wdata_i);
                SEL_CAUSE:    regs_d.cause    = wdata_i;
                default:      ;
            endcase
        end
        if (evt_i.take) begin
            regs_d.ret_addr = align_addr(evt_i.epc);
            regs_d.cause    = evt_i.cause;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q.status   <= STATUS_RESET;
            regs_q.vector   <= '0;
            regs_q.ret_addr <= '0;
            regs_q.cause    <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        case (sel)
            SEL_STATUS:   rdata_o = regs_q.status;
            SEL_VECTOR:   rdata_o = regs_q.vector;
            SEL_RET_ADDR: rdata_o = regs_q.ret_addr;
            SEL_CAUSE:    rdata_o = regs_q.cause;
            default:      rdata_o = '0;
        endcase
    end

    assign regs_o = regs_q;

endmodule

// File: rtl/trap_csr_unit.sv
module trap_csr_unit
    import trap_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [XLEN-1:0]   pc_i,
    input  logic              exc_valid_i,
    input  logic [XLEN-1:0]   exc_cause_i,
    input  logic              env_call_i,
    input  logic              trap_ret_i,
    input  logic              csr_we_i,
    input  logic [CSR_AW-1:0] csr_addr_i,
    input  logic [XLEN-1:0]   csr_wdata_i,
    output logic [XLEN-1:0]   csr_rdata_o,
    output logic              redirect_o,
    output logic [XLEN-1:0]   redirect_pc_o
);

    csr_regs_t regs;
    trap_evt_t evt;

    trap_ctrl i_ctrl (
        .pc_i          (pc_i),
        .exc_valid_i   (exc_valid_i),
        .exc_cause_i   (exc_cause_i),
        .env_call_i    (env_call_i),
        .trap_ret_i    (trap_ret_i),
        .regs_i        (regs),
        .evt_o         (evt),
        .redirect_o    (redirect_o),
        .redirect_pc_o (redirect_pc_o)
    );

    csr_file i_file (
        .clk     (clk),
        .rst     (rst),
        .we_i    (csr_we_i),
        .num_i   (csr_addr_i),
        .wdata_i (csr_wdata_i),
        .evt_i   (evt),
        .rdata_o (csr_rdata_o),
        .regs_o  (regs)
    );

endmodule

// File: rtl/trap_csr_checker.sv
module trap_csr_checker
    import trap_csr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [XLEN-1:0]   pc_i,
    input logic              exc_valid_i,
    input logic [XLEN-1:0]   exc_cause_i,
    input logic              env_call_i,
    input logic              trap_ret_i,
    input logic              csr_we_i,
    input logic [CSR_AW-1:0] csr_addr_i,
    input logic              redirect_o,
    input logic [XLEN-1:0]   redirect_pc_o,
    input csr_regs_t         regs
);

    logic trap;
    assign trap = exc_valid_i | env_call_i;

    p_trap_target_r5: assert property (@(posedge clk) disable iff (rst)
        trap |-> (redirect_o && redirect_pc_o == regs.vector));

    p_epc_capture_r5: assert property (@(posedge clk) disable iff (rst)
        trap |=> (regs.ret_addr == align_addr($past(pc_i))));

    p_env_cause_r6: assert property (@(posedge clk) disable iff (rst)
        (env_call_i && !exc_valid_i) |=> (regs.cause == CAUSE_ENV));

    p_exc_cause_r6: assert property (@(posedge clk) disable iff (rst)
        exc_valid_i |=> (regs.cause == $past(exc_cause_i)));

    p_ret_target_r7: assert property (@(posedge clk) disable iff (rst)
        (trap_ret_i && !trap) |-> (redirect_o && redirect_pc_o == regs.ret_addr));

    p_idle_no_redirect_r7: assert property (@(posedge clk) disable iff (rst)
        (!trap && !trap_ret_i) |-> !redirect_o);

    p_epc_aligned_r4: assert property (@(posedge clk) disable iff (rst)
        regs.ret_addr[ALIGN_BITS-1:0] == '0);

    p_status_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !(csr_we_i && csr_addr_i == NUM_STATUS) |=> $stable(regs.status));

endmodule

bind trap_csr_unit trap_csr_checker i_chk (
    .clk           (clk),
    .rst           (rst),
    .pc_i          (pc_i),
    .exc_valid_i   (exc_valid_i),
    .exc_cause_i   (exc_cause_i),
    .env_call_i    (env_call_i),
    .trap_ret_i    (trap_ret_i),
    .csr_we_i      (csr_we_i),
    .csr_addr_i    (csr_addr_i),
    .redirect_o    (redirect_o),
    .redirect_pc_o (redirect_pc_o),
    .regs          (regs)
);

// File: tb/test_trap_csr_unit.sv
module test_trap_csr_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] pc_i;
    logic        exc_valid_i;
    logic [31:0] exc_cause_i;
    logic        env_call_i;
    logic        trap_ret_i;
    logic        csr_we_i;
    logic [11:0] csr_addr_i;
    logic [31:0] csr_wdata_i;
    logic [31:0] csr_rdata_o;
    logic        redirect_o;
    logic [31:0] redirect_pc_o;

    always #4 clk = ~clk;

    trap_csr_unit i_trap_csr_unit (
        .clk           (clk),
        .rst           (rst),
        .pc_i          (pc_i),
        .exc_valid_i   (exc_valid_i),
        .exc_cause_i   (exc_cause_i),
        .env_call_i    (env_call_i),
        .trap_ret_i    (trap_ret_i),
        .csr_we_i      (csr_we_i),
        .csr_addr_i    (csr_addr_i),
        .csr_wdata_i   (csr_wdata_i),
        .csr_rdata_o   (csr_rdata_o),
        .redirect_o    (redirect_o),
        .redirect_pc_o (redirect_pc_o)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [31:0] m_status, m_vec, m_ret, m_cause;

    function automatic logic [31:0] model_read(input logic [11:0] a);
        case (a)
            12'h300: return m_status;
            12'h305: return m_vec;
            12'h341: return m_ret;
            12'h342: return m_cause;
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic step(input string req, input logic [31:0] pc,
                        input bit exc, input logic [31:0] ecause,
                        input bit env, input bit ret,
                        input bit we, input logic [11:0] addr,
                        input logic [31:0] wdata);
        bit          trap;
        logic [31:0] cause;
        logic [31:0] exp_pc;
        pc_i = pc; exc_valid_i = exc; exc_cause_i = ecause;
        env_call_i = env; trap_ret_i = ret;
        csr_we_i = we; csr_addr_i = addr; csr_wdata_i = wdata;
        #1;
        trap   = exc | env;
        cause  = exc ? ecause : 32'd11;
        exp_pc = trap ? m_vec : m_ret;
        check(req, "rdata", csr_rdata_o, model_read(addr));
        check(req, "redirect", {31'b0, redirect_o}, {31'b0, (trap | ret)});
        if (trap | ret) check(req, "redirect_pc", redirect_pc_o, exp_pc);
        @(posedge clk);
        if (we) begin
            case (addr)
                12'h300: m_status = wdata;
                12'h305: m_vec    = wdata;
                12'h341: m_ret    = wdata & 32'hFFFF_FFFC;
                12'h342: m_cause  = wdata;
                default: ;
            endcase
        end
        if (trap) begin
            m_ret   = pc & 32'hFFFF_FFFC;
            m_cause = cause;
        end
        @(negedge clk);
    endtask

    task automatic rd(input string req, input logic [11:0] a);
        step(req, 32'h0, 0, 32'h0, 0, 0, 0, a, 32'h0);
    endtask

    task automatic wr(input string req, input logic [11:0] a, input logic [31:0] d);
        step(req, 32'h0, 0, 32'h0, 0, 0, 1, a, d);
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        pc_i = '0; exc_valid_i = 0; exc_cause_i = '0; env_call_i = 0;
        trap_ret_i = 0; csr_we_i = 0; csr_addr_i = '0; csr_wdata_i = '0;
        m_status = 32'h0000_1800; m_vec = 0; m_ret = 0; m_cause = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset values
        rd("R1", 12'h300);
        rd("R1", 12'h305);
        rd("R1", 12'h341);
        rd("R1", 12'h342);

        // R10: every status bit is writable
        wr("R10", 12'h300, 32'hFFFF_FFFF);
        rd("R10", 12'h300);
        wr("R10", 12'h300, 32'h0000_0000);
        rd("R10", 12'h300);

        // R3: swap reads the old value, then the new one
        wr("R3", 12'h305, 32'h8000_0100);
        wr("R3", 12'h305, 32'h8000_0180);
        rd("R3", 12'h305);

        // R2: unmapped numbers read zero and write nothing
        wr("R2", 12'h343, 32'hDEAD_BEEF);
        rd("R2", 12'h343);
        wr("R2", 12'h000, 32'h1234_5678);
        rd("R2", 12'h300);
        rd("R2", 12'h305);
        rd("R2", 12'h341);
        rd("R2", 12'h342);

        // R4: unaligned write to the return address
        wr("R4", 12'h341, 32'h0000_1237);
        rd("R4", 12'h341);

        // R5, R6: environment call saves its own address, cause 11
        step("R5", 32'h2000_0010, 0, 32'h0, 1, 0, 0, 12'h341, 32'h0);
        rd("R5", 12'h341);
        rd("R6", 12'h342);
        rd("R10", 12'h300);

        // R7: trap return jumps to the saved address, nothing changes
        step("R7", 32'h8000_0200, 0, 32'h0, 0, 1, 0, 12'h341, 32'h0);
        rd("R7", 12'h341);
        rd("R7", 12'h342);

        // R4, R6: exception with an unaligned PC
        step("R6", 32'h0000_0103, 1, 32'd2, 0, 0, 0, 12'h342, 32'h0);
        rd("R4", 12'h341);
        rd("R6", 12'h342);

        // R6: both sources together, exception cause wins
        step("R6", 32'h0000_0400, 1, 32'd5, 1, 0, 0, 12'h000, 32'h0);
        rd("R6", 12'h342);

        // R8: trap and software write of the saved state
        step("R8", 32'h0000_0500, 0, 32'h0, 1, 0, 1, 12'h341, 32'hAAAA_AAA8);
        rd("R8", 12'h341);
        step("R8", 32'h0000_0600, 1, 32'd7, 0, 0, 1, 12'h342, 32'h0000_0099);
        rd("R8", 12'h342);
        // R8: trap and vector write, redirect uses old vector, write lands
        step("R8", 32'h0000_0700, 0, 32'h0, 1, 0, 1, 12'h305, 32'h9000_0000);
        rd("R8", 12'h305);
        step("R8", 32'h0000_0800, 0, 32'h0, 1, 0, 1, 12'h300, 32'h0000_00F0);
        rd("R8", 12'h300);

        // R9: trap and trap return together
        step("R9", 32'h0000_0900, 1, 32'd3, 0, 1, 0, 12'h341, 32'h0);
        rd("R9", 12'h341);
        rd("R9", 12'h342);

        // R3: mixed pseudo-random stream against the model
        for (int i = 0; i < 400; i++) begin
            logic [11:0] a;
            logic [31:0] r;
            r = $urandom;
            case (r[2:0])
                3'd0: a = 12'h300;
                3'd1: a = 12'h305;
                3'd2, 3'd3: a = 12'h341;
                3'd4: a = 12'h342;
                default: a = 12'($urandom);
            endcase
            step("R3", $urandom, (r[7:5] == 3'd0), 32'($urandom % 16),
                 (r[10:8] == 3'd0), (r[13:11] == 3'd0), r[14], a, $urandom);
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule